// File: doc/BRIEF.md
# Address Translation Unit with Buffer Walk and Software Fallback

This block turns a virtual page number into a physical frame number. Every request first searches a small, fully associative translation cache. A hit answers at once. On a miss the unit reads one slot of a direct-mapped translation table that software keeps in memory. The unit reaches that table through a plain read port. If the slot holds the wanted page, the unit copies the entry into the cache and answers without software help.

If the slot is empty or holds another page, the unit raises a trap line together with the faulting page number. It then holds the request until software pulses resume. After resume the whole lookup runs again from the cache onward. Only one translation is in flight at a time. A flush input empties the cache in a single cycle.

Top module: `xlate_unit`

## Requirements
- R1: A request whose page is cached produces `rsp_valid` for one cycle carrying the cached frame number. `rsp_valid` is seen in the second cycle after the accepting edge, and no memory read is issued.
- R2: A cache miss issues exactly one memory read (`mem_rd_en` high for one cycle). Its address is `tsb_base + (req_vpn[5:0] * 8)`: 64 table slots of 8 bytes each.
- R3: When the read returns with `mem_rsp_ok` high and `mem_rsp_vpn` equal to the full requested page number, the unit answers with `mem_rsp_pfn` and installs the entry. A later request for that page then hits with no memory read.
- R4: When the returned slot is invalid or its page number differs, `trap_req` rises with `trap_vpn` equal to the requested page. It stays high, and no response is given, until `resume` is sampled high.
- R5: After resume the unit repeats the full sequence: cache lookup, then a fresh table read, then another trap if the slot still does not match.
- R6: `req_ready` is low from the accepting edge until the cycle in which the response is presented. At most one translation is outstanding.
- R7: A new entry goes into the lowest-numbered empty cache slot. When all 8 slots are full, a rotating pointer picks the victim. The pointer starts at slot 0 and advances by one after each replacement.
- R8: A one-cycle `flush` empties every cache slot and returns the rotating pointer to slot 0. Afterwards every page misses.
- R9: If `flush` is high in the same cycle as a table-hit refill, the flush wins and the entry is not kept. The response for that request is still delivered.
- R10: After reset, `req_ready` is high and `rsp_valid`, `mem_rd_en` and `trap_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the translation cache |
| tsb_base | input | 32 | Byte address of the in-memory table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vpn | input | 20 | Virtual page number to translate |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_pfn | output | 16 | Physical frame number |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 32 | Table slot byte address |
| mem_rsp_valid | input | 1 | Table read data returned |
| mem_rsp_ok | input | 1 | Returned slot holds a valid entry |
| mem_rsp_vpn | input | 20 | Page number tag of the returned slot |
| mem_rsp_pfn | input | 16 | Frame number of the returned slot |
| trap_req | output | 1 | Software must handle a table miss |
| trap_vpn | output | 20 | Page number that missed |
| resume | input | 1 | Software done; retry the translation |

## Verification
A flush and a table-hit refill can land in the same cycle. The bench provokes this by having its memory model raise `flush` on the exact cycle it returns a matching slot. The scoreboard must still receive the correct frame for that request. A repeat request for the same page must then cost a fresh memory read, and so must a page that was cached before the flush.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RD,
    ST_WAIT,
    ST_TRAP
  } xl_state_e;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int DEPTH = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [PFN_W-1:0] hit_pfn,
  output logic [DEPTH-1:0] hit_vec,
  output logic [DEPTH-1:0] valid_vec,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [VPN_W-1:0] tag_q [DEPTH];
  logic [PFN_W-1:0] pfn_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [PTR_W-1:0] rr_q;
  logic [PTR_W-1:0] free_idx;
  logic             any_free;
  logic [PTR_W-1:0] victim;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_vpn);
  end

  assign hit       = |hit_vec;
  assign valid_vec = valid_q;

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) hit_pfn = hit_pfn | pfn_q[i];
    end
  end

  // lowest empty slot wins
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = PTR_W'(i);
      end
    end
  end

  assign victim = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (wr_en) begin
      valid_q[victim] <= 1'b1;
      if (!any_free) rr_q <= (rr_q == PTR_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[victim] <= wr_vpn;
      pfn_q[victim] <= wr_pfn;
    end
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int VPN_W       = 20,
  parameter int PFN_W       = 16,
  parameter int MEM_AW      = 32,
  parameter int TSB_IDX_W   = 6,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] tsb_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  output logic              rsp_valid,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_ok,
  input  logic [VPN_W-1:0]  mem_rsp_vpn,
  input  logic [PFN_W-1:0]  mem_rsp_pfn,
  output logic              trap_req,
  output logic [VPN_W-1:0]  trap_vpn,
  input  logic              resume,
  output logic [VPN_W-1:0]  cur_vpn,
  input  logic              tlb_hit,
  input  logic [PFN_W-1:0]  tlb_pfn,
  output logic              tsb_hit,
  output logic              tsb_miss
);
  function automatic logic [MEM_AW-1:0] tsb_slot_addr(input logic [MEM_AW-1:0] base,
                                                      input logic [VPN_W-1:0]  vpn);
    logic [MEM_AW-1:0] idx;
    idx = MEM_AW'(vpn[TSB_IDX_W-1:0]);
    return base + (idx << ENTRY_SHIFT);
  endfunction

  function automatic logic slot_matches(input logic ok, input logic [VPN_W-1:0] tag,
                                        input logic [VPN_W-1:0] vpn);
    return ok && (tag == vpn);
  endfunction

  xl_state_e        st_q;
  logic [VPN_W-1:0] vpn_q;

  assign cur_vpn     = vpn_q;
  assign req_ready   = (st_q == ST_IDLE);
  assign mem_rd_en   = (st_q == ST_RD);
  assign mem_rd_addr = tsb_slot_addr(tsb_base, vpn_q);
  assign trap_req    = (st_q == ST_TRAP);
  assign trap_vpn    = vpn_q;
  assign tsb_hit     = (st_q == ST_WAIT) && mem_rsp_valid &&
                       slot_matches(mem_rsp_ok, mem_rsp_vpn, vpn_q);
  assign tsb_miss    = (st_q == ST_WAIT) && mem_rsp_valid &&
                       !slot_matches(mem_rsp_ok, mem_rsp_vpn, vpn_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      vpn_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_pfn   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          vpn_q <= req_vpn;
          st_q  <= ST_LOOK;
        end
        ST_LOOK: if (tlb_hit) begin
          rsp_valid <= 1'b1;
          rsp_pfn   <= tlb_pfn;
          st_q      <= ST_IDLE;
        end else begin
          st_q <= ST_RD;
        end
        ST_RD: st_q <= ST_WAIT;
        ST_WAIT: if (tsb_hit) begin
          rsp_valid <= 1'b1;
          rsp_pfn   <= mem_rsp_pfn;
          st_q      <= ST_IDLE;
        end else if (tsb_miss) begin
          st_q <= ST_TRAP;
        end
        ST_TRAP: if (resume) st_q <= ST_LOOK;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit #(
  parameter int VPN_W       = 20,
  parameter int PFN_W       = 16,
  parameter int MEM_AW      = 32,
  parameter int TLB_DEPTH   = 8,
  parameter int TSB_IDX_W   = 6,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [MEM_AW-1:0] tsb_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  output logic              rsp_valid,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_ok,
  input  logic [VPN_W-1:0]  mem_rsp_vpn,
  input  logic [PFN_W-1:0]  mem_rsp_pfn,
  output logic              trap_req,
  output logic [VPN_W-1:0]  trap_vpn,
  input  logic              resume
);
  logic [VPN_W-1:0]     cur_vpn;
  logic                 tlb_hit;
  logic [PFN_W-1:0]     tlb_pfn;
  logic [TLB_DEPTH-1:0] hit_vec;
  logic [TLB_DEPTH-1:0] valid_vec;
  logic                 tsb_hit;
  logic                 tsb_miss;

  xlate_ctrl #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .MEM_AW(MEM_AW),
    .TSB_IDX_W(TSB_IDX_W), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tsb_base(tsb_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_pfn(rsp_pfn),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ok(mem_rsp_ok),
    .mem_rsp_vpn(mem_rsp_vpn), .mem_rsp_pfn(mem_rsp_pfn),
    .trap_req(trap_req), .trap_vpn(trap_vpn), .resume(resume),
    .cur_vpn(cur_vpn), .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
    .tsb_hit(tsb_hit), .tsb_miss(tsb_miss)
  );

  xlate_tlb #(
    .DEPTH(TLB_DEPTH), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(cur_vpn), .hit(tlb_hit), .hit_pfn(tlb_pfn),
    .hit_vec(hit_vec), .valid_vec(valid_vec),
    .wr_en(tsb_hit), .wr_vpn(cur_vpn), .wr_pfn(mem_rsp_pfn)
  );
endmodule

// File: rtl/xlate_unit_chk.sv
module xlate_unit_chk #(
  parameter int VPN_W     = 20,
  parameter int TLB_DEPTH = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic                 mem_rd_en,
  input logic                 trap_req,
  input logic [VPN_W-1:0]     trap_vpn,
  input logic                 resume,
  input logic [TLB_DEPTH-1:0] hit_vec,
  input logic [TLB_DEPTH-1:0] valid_vec
);
  p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  p_no_duplicate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_trap_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !resume) |=> (trap_req && $stable(trap_vpn)));

  p_trap_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !rsp_valid);

  p_retry_after_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && resume) |=> (!trap_req && !req_ready));

  p_busy_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || trap_req) |-> !req_ready);

  p_ready_with_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));
endmodule

bind xlate_unit xlate_unit_chk #(.VPN_W(VPN_W), .TLB_DEPTH(TLB_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_rd_en(mem_rd_en), .trap_req(trap_req),
  .trap_vpn(trap_vpn), .resume(resume), .hit_vec(hit_vec), .valid_vec(valid_vec)
);

// File: tb/xlate_unit_tb.sv
`timescale 1ns/1ps
module xlate_unit_tb;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush;
  logic        flush_main = 1'b0;
  logic        flush_mem = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic        rsp_valid;
  logic [15:0] rsp_pfn;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ok = 1'b0;
  logic [19:0] mem_rsp_vpn = '0;
  logic [15:0] mem_rsp_pfn = '0;
  logic        trap_req;
  logic [19:0] trap_vpn;
  logic        resume = 1'b0;

  assign flush = flush_main | flush_mem;

  always #2 clk = ~clk;

  xlate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .tsb_base(BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_pfn(rsp_pfn),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ok(mem_rsp_ok),
    .mem_rsp_vpn(mem_rsp_vpn), .mem_rsp_pfn(mem_rsp_pfn),
    .trap_req(trap_req), .trap_vpn(trap_vpn), .resume(resume)
  );

  int checks = 0;
  int bad = 0;
  int reads = 0;
  int traps = 0;
  int req_traps = 0;
  int fill_at = 0;
  logic [15:0] fill_pfn = '0;
  logic        flush_on_rsp = 1'b0;
  logic [19:0] last_vpn = '0;
  logic [15:0] exp_q[$];

  logic        tsb_ok  [64];
  logic [19:0] tsb_tag [64];
  logic [15:0] tsb_pfn [64];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] vpage(input int i);
    return 20'h00A00 + 20'(i);
  endfunction

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected response", rsp_pfn, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rsp_pfn == e, "R1/R3 response frame", rsp_pfn, e);
      end
    end
  end

  // memory model for the table
  initial forever begin
    @(negedge clk);
    if (mem_rd_en) begin
      int idx;
      logic [31:0] ea;
      reads++;
      ea = BASE + 32'(last_vpn % 64) * 32'd8;
      chk(mem_rd_addr == ea, "R2 slot address", mem_rd_addr, ea);
      idx = int'((mem_rd_addr - BASE) >> 3) % 64;
      @(posedge clk); #1;
      mem_rsp_valid = 1'b1;
      mem_rsp_ok    = tsb_ok[idx];
      mem_rsp_vpn   = tsb_tag[idx];
      mem_rsp_pfn   = tsb_pfn[idx];
      flush_mem     = flush_on_rsp;
      @(posedge clk); #1;
      mem_rsp_valid = 1'b0;
      flush_mem     = 1'b0;
    end
  end

  // software trap handler
  initial forever begin
    @(negedge clk);
    if (trap_req) begin
      traps++;
      req_traps++;
      chk(trap_vpn == last_vpn, "R4 trap page", trap_vpn, last_vpn);
      repeat (3) begin
        @(negedge clk);
        chk(trap_req && !rsp_valid, "R4 trap held without response", {trap_req, rsp_valid}, 2);
      end
      if (req_traps == fill_at) begin
        tsb_ok[trap_vpn % 64]  = 1'b1;
        tsb_tag[trap_vpn % 64] = trap_vpn;
        tsb_pfn[trap_vpn % 64] = fill_pfn;
      end
      @(posedge clk); #1 resume = 1'b1;
      @(posedge clk); #1 resume = 1'b0;
    end
  end

  task automatic issue(input logic [19:0] v, input logic [15:0] p);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vpn   = v;
    last_vpn  = v;
    exp_q.push_back(p);
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (exp_q.size() != 0 || !req_ready);
  endtask

  task automatic xlate(input logic [19:0] v, input logic [15:0] p, input int exp_reads,
                       input string req);
    int r0;
    r0 = reads;
    req_traps = 0;
    issue(v, p);
    wait_done();
    chk(reads - r0 == exp_reads, req, reads - r0, exp_reads);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      tsb_ok[i] = 1'b0; tsb_tag[i] = '0; tsb_pfn[i] = '0;
    end
    for (int i = 0; i < 10; i++) begin
      tsb_ok[i] = 1'b1; tsb_tag[i] = vpage(i); tsb_pfn[i] = 16'h1000 + 16'(i);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en && !trap_req, "R10 reset state",
        {req_ready, rsp_valid, mem_rd_en, trap_req}, 4'b1000);

    // fill the cache from the table, then hit everywhere
    for (int i = 0; i < 8; i++) xlate(vpage(i), 16'h1000 + 16'(i), 1, "R2/R3 miss walks once");
    for (int i = 0; i < 8; i++) xlate(vpage(i), 16'h1000 + 16'(i), 0, "R1/R3 hit without read");

    // hit timing and ready window
    begin
      int r0;
      r0 = reads;
      @(negedge clk);
      req_valid = 1'b1; req_vpn = vpage(5); last_vpn = vpage(5);
      exp_q.push_back(16'h1005);
      @(posedge clk); #1 req_valid = 1'b0;
      @(negedge clk);
      chk(!req_ready, "R6 ready low while busy", req_ready, 0);
      chk(!rsp_valid, "R1 no response in lookup cycle", rsp_valid, 0);
      @(negedge clk);
      chk(rsp_valid, "R1 hit response timing", rsp_valid, 1);
      chk(req_ready, "R6 ready back with response", req_ready, 1);
      chk(reads == r0, "R1 hit issues no read", reads - r0, 0);
    end

    // rotating replacement
    xlate(vpage(8), 16'h1008, 1, "R7 ninth fill evicts slot 0");
    xlate(vpage(1), 16'h1001, 0, "R7 slot 1 kept");
    xlate(vpage(0), 16'h1000, 1, "R7 evicted page misses");
    xlate(vpage(1), 16'h1001, 1, "R7 pointer moved to slot 1");
    xlate(vpage(3), 16'h1003, 0, "R7 slot 3 kept");
    xlate(vpage(2), 16'h1002, 1, "R7 pointer moved to slot 2");

    // flush
    @(posedge clk); #1 flush_main = 1'b1;
    @(posedge clk); #1 flush_main = 1'b0;
    xlate(vpage(4), 16'h1004, 1, "R8 miss after flush");
    xlate(vpage(4), 16'h1004, 0, "R8 refill after flush hits");

    // empty slot: one trap, software fills, retry succeeds
    fill_at = 1; fill_pfn = 16'h2B10;
    begin
      int t0;
      t0 = traps;
      xlate(20'h00B10, 16'h2B10, 2, "R5 retry re-reads table");
      chk(traps - t0 == 1, "R4 one trap on empty slot", traps - t0, 1);
    end

    // tag mismatch: two traps before software fills
    tsb_ok[6'h11] = 1'b1; tsb_tag[6'h11] = 20'h00D11; tsb_pfn[6'h11] = 16'h5555;
    fill_at = 2; fill_pfn = 16'h2C11;
    begin
      int t0;
      t0 = traps;
      xlate(20'h00C11, 16'h2C11, 3, "R5 full sequence repeated");
      chk(traps - t0 == 2, "R5 trap again while still missing", traps - t0, 2);
    end
    fill_at = 0;
    xlate(20'h00C11, 16'h2C11, 0, "R3 entry installed after retry");

    // flush in the refill cycle
    flush_on_rsp = 1'b1;
    xlate(vpage(9), 16'h1009, 1, "R9 response still given");
    flush_on_rsp = 1'b0;
    xlate(vpage(9), 16'h1009, 1, "R9 refill dropped by flush");
    xlate(20'h00B10, 16'h2B10, 1, "R9 older entry gone too");

    chk(exp_q.size() == 0, "R1 all responses seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule